// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is the register front end of a general-purpose I/O unit with 128 pins, grouped as four banks of 32. A host reaches it through a plain synchronous read/write bus with no wait states. Through that bus it sets pin directions, changes output values and programs the edge-detection enables and the alternate-function words. It also reads back a composite level word for each bank and clears sticky edge flags. The level word carries the driven value for output pins and the synchronised input value for input pins.

Output latches are never written directly. A write to a bank's set word turns latch bits on, and a write to its clear word turns them off, so several owners can share a bank without read-modify-write. An external edge detector takes the synchronised pins and the enables from this block and returns one-cycle event pulses. Those pulses land in sticky status bits that the host clears by writing ones.

The register window is irregular. Banks 0 to 2 are interleaved at low offsets, and bank 3 sits 0x100 above its siblings, except for its alternate-function pair, which continues the low run.

Top module: `banked_gpio_ctrl`

## Requirements
- R1: After reset every register is zero: `pin_oe` and `pin_out` are all 0 and direction, level, enable, status and alternate-function reads return 0.
- R2: The level word of bank b is at byte offset 4b for b=0..2 and at 0x100 for bank 3. The direction word is at 0x0C+4b for b=0..2 and at 0x10C for bank 3. A direction bit of 1 makes the pin an output.
- R3: Writing value v to a set word (0x18+4b for b=0..2, 0x118 for bank 3) ORs v into that bank's output latch.
- R4: Writing v to a clear word (0x24+4b for b=0..2, 0x124 for bank 3) zeroes every latch bit where v is 1 and leaves the other bits alone.
- R5: Set and clear words read back as zero.
- R6: A level read returns, for each pin, the latch bit where direction is 1 and the synchronised input bit where direction is 0. Writes to a level word are ignored.
- R7: `pin_oe` equals the direction bits, and `pin_out` equals latch AND direction, so an input pin drives 0.
- R8: Any access at byte offset 0x200 or above writes nothing, reads as zero and raises no error.
- R9: Inside the window, an access to an unassigned offset or one with address bits [1:0] not zero changes nothing and reads as zero. It raises `bus_err` for exactly the cycle after the access.
- R10: `pin_in` passes through two flops. A change becomes visible on `pin_sync` and in level reads two clock edges later, not one.
- R11: A status bit (bank b at 0x48+4b for b=0..2, 0x148 for bank 3) is set by a pulse on `edge_evt` and is cleared by writing 1 to it. Writing 0 leaves it unchanged. An event in the same cycle as a clearing write keeps the bit set.
- R12: The rise-enable (0x30+4b / 0x130), fall-enable (0x3C+4b / 0x13C), alternate-low (0x54+8b) and alternate-high (0x58+8b) words read back as written. They drive `rise_en`, `fall_en` and `alt_fn`, where word index 2b+hi occupies `alt_fn[(2b+hi)*32 +: 32]`.
- R13: Read data appears on `bus_rdata` in the cycle after `bus_rd` and is zero in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| bus_err | output | 1 | One-cycle pulse for an unmapped in-window access |
| pin_in | input | 128 | Raw asynchronous pin inputs |
| pin_sync | output | 128 | Synchronised pin levels for the edge detector |
| pin_out | output | 128 | Driven pin values |
| pin_oe | output | 128 | Pin output enables |
| rise_en | output | 128 | Rising-edge enables |
| fall_en | output | 128 | Falling-edge enables |
| edge_evt | input | 128 | One-cycle edge events from the detector |
| edge_status | output | 128 | Sticky edge flags |
| alt_fn | output | 256 | Alternate-function words, two per bank |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never asserted together and that `bus_addr` holds steady only for the one cycle of a strobe. The bench drives every transfer as a single-cycle strobe on the falling edge and keeps the two strobes exclusive. The sticky-status property takes `edge_evt` as any pattern the detector produces. The bench pulses single bits, including one pulse aligned with a clearing write to the same bit.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int NUM_BANKS  = 4;   // fixed: the window layout names four banks
  localparam int BANK_W     = 32;
  localparam int PIN_W      = NUM_BANKS * BANK_W;
  localparam int BANK_IDX_W = $clog2(NUM_BANKS);
  localparam int WIN_BITS   = 9;   // window is 512 bytes

  typedef enum logic [2:0] {
    RK_LEVEL = 3'd0,
    RK_DIR   = 3'd1,
    RK_SET   = 3'd2,
    RK_CLR   = 3'd3,
    RK_RISE  = 3'd4,
    RK_FALL  = 3'd5,
    RK_STAT  = 3'd6,
    RK_ALT   = 3'd7
  } reg_kind_e;

  typedef struct packed {
    logic                  hit;
    reg_kind_e             kind;
    logic [BANK_IDX_W-1:0] bank;
    logic                  alt_hi;
  } reg_sel_t;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_ctrl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel,
  output logic              in_window
);
  logic [6:0] w;
  logic [6:0] wh;

  assign in_window = (addr >> WIN_BITS) == '0;
  assign w  = addr[WIN_BITS-1:2];
  assign wh = w - 7'd64;

  always_comb begin
    sel = '0;
    if (w < 7'd21) begin
      // three-wide interleave of banks 0..2 for seven register kinds
      sel.hit  = 1'b1;
      sel.kind = reg_kind_e'(3'(w / 7'd3));
      sel.bank = BANK_IDX_W'(w % 7'd3);
    end else if (w < 7'd29) begin
      // alternate-function pairs for all four banks
      sel.hit    = 1'b1;
      sel.kind   = RK_ALT;
      sel.bank   = BANK_IDX_W'((w - 7'd21) >> 1);
      sel.alt_hi = ~w[0];
    end else if (w >= 7'd64 && wh < 7'd21 && (wh % 7'd3) == 7'd0) begin
      // relocated bank 3 copies
      sel.hit  = 1'b1;
      sel.kind = reg_kind_e'(3'(wh / 7'd3));
      sel.bank = BANK_IDX_W'(NUM_BANKS - 1);
    end
    if (!in_window || addr[1:0] != 2'b00) sel.hit = 1'b0;
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 128,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctrl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  reg_kind_e kind,
  input  logic      alt_sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] sync_in,
  input  logic [W-1:0] evt,
  output logic [W-1:0] drv,
  output logic [W-1:0] oe,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall,
  output logic [W-1:0] stat,
  output logic [W-1:0] alt_lo,
  output logic [W-1:0] alt_hi,
  output logic [W-1:0] rd_word
);
  logic [W-1:0] lat_q, dir_q, rise_q, fall_q, stat_q, alo_q, ahi_q;
  logic [W-1:0] stat_clr;

  assign stat_clr = (wr_en && kind == RK_STAT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q  <= '0;
      dir_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      alo_q  <= '0;
      ahi_q  <= '0;
    end else begin
      if (wr_en) begin
        case (kind)
          RK_DIR:  dir_q  <= wdata;
          RK_SET:  lat_q  <= lat_q | wdata;
          RK_CLR:  lat_q  <= lat_q & ~wdata;
          RK_RISE: rise_q <= wdata;
          RK_FALL: fall_q <= wdata;
          RK_ALT: begin
            if (alt_sel) ahi_q <= wdata;
            else         alo_q <= wdata;
          end
          default: ;
        endcase
      end
      // a fresh event outranks a same-cycle clear
      stat_q <= (stat_q & ~stat_clr) | evt;
    end
  end

  always_comb begin
    case (kind)
      RK_LEVEL: rd_word = (lat_q & dir_q) | (sync_in & ~dir_q);
      RK_DIR:   rd_word = dir_q;
      RK_RISE:  rd_word = rise_q;
      RK_FALL:  rd_word = fall_q;
      RK_STAT:  rd_word = stat_q;
      RK_ALT:   rd_word = alt_sel ? ahi_q : alo_q;
      default:  rd_word = '0;
    endcase
  end

  assign drv    = lat_q & dir_q;
  assign oe     = dir_q;
  assign rise   = rise_q;
  assign fall   = fall_q;
  assign stat   = stat_q;
  assign alt_lo = alo_q;
  assign alt_hi = ahi_q;
endmodule

// File: rtl/banked_gpio_ctrl.sv
module banked_gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BANK_W-1:0]    bus_wdata,
  output logic [BANK_W-1:0]    bus_rdata,
  output logic                 bus_err,
  input  logic [PIN_W-1:0]     pin_in,
  output logic [PIN_W-1:0]     pin_sync,
  output logic [PIN_W-1:0]     pin_out,
  output logic [PIN_W-1:0]     pin_oe,
  output logic [PIN_W-1:0]     rise_en,
  output logic [PIN_W-1:0]     fall_en,
  input  logic [PIN_W-1:0]     edge_evt,
  output logic [PIN_W-1:0]     edge_status,
  output logic [2*PIN_W-1:0]   alt_fn
);
  reg_sel_t          sel;
  logic              in_window;
  logic [BANK_W-1:0] rd_words [NUM_BANKS];
  logic [BANK_W-1:0] rdata_q;
  logic              err_q;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr      (bus_addr),
    .sel       (sel),
    .in_window (in_window)
  );

  gpio_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_in),
    .dout  (pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = bus_wr && sel.hit && (sel.bank == BANK_IDX_W'(b));

    gpio_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_wr),
      .kind    (sel.kind),
      .alt_sel (sel.alt_hi),
      .wdata   (bus_wdata),
      .sync_in (pin_sync[b*BANK_W +: BANK_W]),
      .evt     (edge_evt[b*BANK_W +: BANK_W]),
      .drv     (pin_out[b*BANK_W +: BANK_W]),
      .oe      (pin_oe[b*BANK_W +: BANK_W]),
      .rise    (rise_en[b*BANK_W +: BANK_W]),
      .fall    (fall_en[b*BANK_W +: BANK_W]),
      .stat    (edge_status[b*BANK_W +: BANK_W]),
      .alt_lo  (alt_fn[(2*b)*BANK_W +: BANK_W]),
      .alt_hi  (alt_fn[(2*b+1)*BANK_W +: BANK_W]),
      .rd_word (rd_words[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= (bus_rd && sel.hit) ? rd_words[sel.bank] : '0;
      err_q   <= (bus_rd || bus_wr) && in_window && !sel.hit;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
endmodule

// File: rtl/banked_gpio_ctrl_chk.sv
module banked_gpio_ctrl_chk
  import gpio_ctrl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [BANK_W-1:0]  bus_rdata,
  input logic               bus_err,
  input logic [PIN_W-1:0]   pin_out,
  input logic [PIN_W-1:0]   pin_oe,
  input logic [PIN_W-1:0]   edge_evt,
  input logic [PIN_W-1:0]   edge_status
);
  logic hi_acc;
  assign hi_acc = (bus_rd || bus_wr) && ((bus_addr >> WIN_BITS) != '0);

  AST_INPUT_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);                                          // R7
  AST_OE_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pin_oe));                                        // R7
  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |=> !bus_err);                                   // R9
  AST_HIGH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    hi_acc |=> !bus_err);                                                // R8
  AST_HIGH_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hi_acc) |=> bus_rdata == '0);                             // R8
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);                                        // R13
  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt != '0) |=> (edge_status & $past(edge_evt)) == $past(edge_evt)); // R11
endmodule

bind banked_gpio_ctrl banked_gpio_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/banked_gpio_ctrl_test.sv
module banked_gpio_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_err;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_sync, pin_out, pin_oe, rise_en, fall_en, edge_status;
  logic [127:0] edge_evt = '0;
  logic [255:0] alt_fn;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_gpio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .pin_in(pin_in), .pin_sync(pin_sync),
    .pin_out(pin_out), .pin_oe(pin_oe), .rise_en(rise_en),
    .fall_en(fall_en), .edge_evt(edge_evt), .edge_status(edge_status),
    .alt_fn(alt_fn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic e);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    e = bus_err;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; e = bus_err;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic e;
    chk("R1 oe", pin_oe[31:0] | pin_oe[127:96], 32'h0);
    chk("R1 out", pin_out[63:32] | pin_out[95:64], 32'h0);
    rd(12'h00C, d, e); chk("R1 dir0", d, 32'h0);
    rd(12'h100, d, e); chk("R1 level3", d, 32'h0);
    rd(12'h148, d, e); chk("R1 stat3", d, 32'h0);
    chk("R1 alt", alt_fn[31:0] | alt_fn[255:224], 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] d; logic e;
    wr(12'h00C, 32'h1111_0001, e);
    wr(12'h010, 32'h2222_0002, e);
    wr(12'h014, 32'h3333_0003, e);
    wr(12'h10C, 32'h4444_0004, e);
    rd(12'h00C, d, e); chk("R2 dir0", d, 32'h1111_0001);
    rd(12'h010, d, e); chk("R2 dir1", d, 32'h2222_0002);
    rd(12'h014, d, e); chk("R2 dir2", d, 32'h3333_0003);
    rd(12'h10C, d, e); chk("R2 dir3", d, 32'h4444_0004);
    chk("R7 oe3", pin_oe[127:96], 32'h4444_0004);
    chk("R7 oe0", pin_oe[31:0], 32'h1111_0001);
  endtask

  task automatic t_setclr;
    logic [31:0] d; logic e;
    wr(12'h010, 32'hFFFF_FFFF, e);
    wr(12'h01C, 32'hF0F0_0000, e);
    wr(12'h01C, 32'h0000_00FF, e);
    rd(12'h004, d, e); chk("R3 set ors", d, 32'hF0F0_00FF);
    wr(12'h028, 32'hF000_000F, e);
    rd(12'h004, d, e); chk("R4 clear", d, 32'h00F0_00F0);
    chk("R7 out1", pin_out[63:32], 32'h00F0_00F0);
    rd(12'h01C, d, e); chk("R5 set reads 0", d, 32'h0);
    rd(12'h028, d, e); chk("R5 clr reads 0", d, 32'h0);
    wr(12'h004, 32'hFFFF_FFFF, e);
    rd(12'h004, d, e); chk("R6 level write ignored", d, 32'h00F0_00F0);
  endtask

  task automatic t_mix;
    logic [31:0] d; logic e;
    wr(12'h014, 32'h0000_FFFF, e);
    wr(12'h020, 32'hFFFF_FFFF, e);
    @(negedge clk); pin_in[95:64] = 32'hABCD_1234;
    repeat (3) @(negedge clk);
    rd(12'h008, d, e); chk("R6 mixed level", d, 32'hABCD_FFFF);
    chk("R7 input drives 0", pin_out[95:64], 32'h0000_FFFF);
  endtask

  task automatic t_sync;
    logic [31:0] d; logic e;
    wr(12'h10C, 32'h0, e);
    @(negedge clk); pin_in[127:96] = 32'h5A5A_5A5A;
    @(posedge clk); #1;
    chk("R10 one edge", pin_sync[127:96], 32'h0);
    @(posedge clk); #1;
    chk("R10 two edges", pin_sync[127:96], 32'h5A5A_5A5A);
    rd(12'h100, d, e); chk("R10 level3", d, 32'h5A5A_5A5A);
  endtask

  task automatic t_high;
    logic [31:0] d; logic e;
    wr(12'h20C, 32'hFFFF_FFFF, e); chk("R8 write err", {31'd0, e}, 32'h0);
    rd(12'h00C, d, e); chk("R8 no alias", d, 32'h1111_0001);
    rd(12'h20C, d, e); chk("R8 read zero", d, 32'h0);
    chk("R8 read err", {31'd0, e}, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic e;
    rd(12'h074, d, e);
    chk("R9 read zero", d, 32'h0);
    chk("R9 err pulse", {31'd0, e}, 32'h1);
    @(negedge clk); chk("R9 err one cycle", {31'd0, bus_err}, 32'h0);
    wr(12'h104, 32'hFFFF_FFFF, e); chk("R9 write err", {31'd0, e}, 32'h1);
    chk("R9 oe kept", pin_oe[127:96], 32'h0);
    wr(12'h00D, 32'hFFFF_FFFF, e); chk("R9 misaligned err", {31'd0, e}, 32'h1);
    rd(12'h00C, d, e); chk("R9 misaligned ignored", d, 32'h1111_0001);
  endtask

  task automatic t_status;
    logic [31:0] d; logic e;
    @(negedge clk); edge_evt[5] = 1'b1;
    @(negedge clk); edge_evt[5] = 1'b0;
    rd(12'h048, d, e); chk("R11 event sets", d, 32'h0000_0020);
    wr(12'h048, 32'h0000_0001, e);
    rd(12'h048, d, e); chk("R11 zero write keeps", d, 32'h0000_0020);
    wr(12'h048, 32'h0000_0020, e);
    rd(12'h048, d, e); chk("R11 w1c", d, 32'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'h148; bus_wdata = 32'h80; edge_evt[103] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; edge_evt[103] = 1'b0;
    rd(12'h148, d, e); chk("R11 event beats clear", d, 32'h80);
    chk("R11 status port", edge_status[127:96], 32'h80);
  endtask

  task automatic t_cfg;
    logic [31:0] d; logic e;
    wr(12'h034, 32'h1234_5678, e);
    wr(12'h13C, 32'h0F0F_0F0F, e);
    wr(12'h068, 32'hCAFE_F00D, e);
    wr(12'h06C, 32'h1111_2222, e);
    rd(12'h034, d, e); chk("R12 rise1", d, 32'h1234_5678);
    rd(12'h13C, d, e); chk("R12 fall3", d, 32'h0F0F_0F0F);
    rd(12'h068, d, e); chk("R12 alt2 hi", d, 32'hCAFE_F00D);
    rd(12'h06C, d, e); chk("R12 alt3 lo", d, 32'h1111_2222);
    chk("R12 rise port", rise_en[63:32], 32'h1234_5678);
    chk("R12 fall port", fall_en[127:96], 32'h0F0F_0F0F);
    chk("R12 alt port hi2", alt_fn[191:160], 32'hCAFE_F00D);
    chk("R12 alt port lo3", alt_fn[223:192], 32'h1111_2222);
  endtask

  task automatic t_rdtiming;
    logic [31:0] d; logic e;
    rd(12'h010, d, e); chk("R13 data next cycle", d, 32'hFFFF_FFFF);
    @(negedge clk); chk("R13 idle zero", bus_rdata, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_setclr();
    t_mix();
    t_sync();
    t_high();
    t_unmapped();
    t_status();
    t_cfg();
    t_rdtiming();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule